// File: doc/BRIEF.md
# Receive Buffer Filter Match Engine

This block chooses the storage destination for each received frame. When a frame completes and is reported as well formed, the engine walks the receive buffer descriptors one per clock in rising index order. At each step it compares the frame identifier, the cycle counter value and the arrival channel against that buffer's filter. The first enabled buffer whose filter accepts the frame is chosen. No attempt is made to find the closest fit. If no dedicated buffer accepts the frame, a single FIFO filter is tried. The frame then goes to the FIFO, or it is dropped.

The host locks a buffer before reading it. While a buffer is locked, frames aimed at it are parked in shadow slots, two per channel. Each parked frame is written into the buffer when the host releases it. A second frame for the same locked buffer replaces the parked one and raises a frame-lost pulse. Every write into a buffer sets that buffer's full flag. The interrupt output is the OR of the full flags whose enable bits are set. Frame decoding and payload storage are handled elsewhere. This block produces the destination decision and the per-buffer update strobes.

Top module: `rx_filter_engine`

## Requirements
- R1: A frame reported with `frm_valid_i` high and `frm_ok_i` low is ignored. It produces no `done_o` pulse, no update strobe and no full-flag change.
- R2: The scan begins at index `FIFO_BUFS`, the first index above the FIFO region, and advances upward. The lowest matching index is reported in `done_idx_o`. Indices below `FIFO_BUFS` are never chosen as dedicated buffers.
- R3: A frame that no dedicated buffer accepts is tested against the FIFO filter (gated by `fifo_en_i`). The result code is 2 (FIFO) on a match, with a one-cycle `fifo_wr_o` pulse. Otherwise the result code is 3 (drop).
- R4: Each filter field is compared only on the bits whose mask bit is 1, so a field with an all-zero mask always matches. The channel field is compared only when its mask bit is 1. Channel A is encoded as 0 and channel B as 1.
- R5: A store into an unlocked buffer has result code 0. It pulses that buffer's bit of `upd_o` in the same cycle as `done_o` and sets its full flag. A buffer that is already full is overwritten the same way.
- R6: `irq_o` is high exactly when some buffer has both its full flag and its `irq_en_i` bit set. A `clr_full_i` pulse clears the flag on the following edge.
- R7: `lock_ack_o[i]` follows `lock_req_i[i]` one clock later, both when the lock is granted and when it is released.
- R8: A frame aimed at a locked buffer has result code 1 (deferred) and leaves that buffer's flag and strobe untouched. On release, `upd_o[i]` pulses once and the full flag is set, in the same cycle that `lock_ack_o[i]` falls.
- R9: A second deferred frame for a buffer that is still locked raises `lost_o` together with `done_o`. Release still delivers a single update.
- R10: The engine checks one buffer per clock. If the decision is made at scan offset k, `done_o` rises k+1 clocks after the edge that accepted the frame. When nothing matches, k is the offset of the last buffer.
- R11: A buffer whose `buf_en_i` bit is 0 is skipped, whatever its filter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frm_valid_i | input | 1 | Frame-complete strobe |
| frm_ok_i | input | 1 | Frame is syntactically and semantically valid |
| frm_id_i | input | ID_W | Received frame identifier |
| frm_cyc_i | input | CYC_W | Received cycle count |
| frm_chan_i | input | 1 | Arrival channel (0 = A, 1 = B) |
| buf_en_i | input | NUM_BUF | Buffer configured for reception |
| buf_id_i | input | NUM_BUF*ID_W | Per-buffer identifier filter values |
| buf_id_msk_i | input | NUM_BUF*ID_W | Per-buffer identifier compare masks |
| buf_cyc_i | input | NUM_BUF*CYC_W | Per-buffer cycle filter values |
| buf_cyc_msk_i | input | NUM_BUF*CYC_W | Per-buffer cycle compare masks |
| buf_chan_i | input | NUM_BUF | Per-buffer channel filter value |
| buf_chan_msk_i | input | NUM_BUF | Per-buffer channel compare enable |
| irq_en_i | input | NUM_BUF | Interrupt enable per full flag |
| fifo_en_i | input | 1 | FIFO fallback enabled |
| fifo_id_i | input | ID_W | FIFO identifier filter value |
| fifo_id_msk_i | input | ID_W | FIFO identifier compare mask |
| fifo_cyc_i | input | CYC_W | FIFO cycle filter value |
| fifo_cyc_msk_i | input | CYC_W | FIFO cycle compare mask |
| fifo_chan_i | input | 1 | FIFO channel filter value |
| fifo_chan_msk_i | input | 1 | FIFO channel compare enable |
| lock_req_i | input | NUM_BUF | Host lock request per buffer |
| lock_ack_o | output | NUM_BUF | Lock acknowledge per buffer |
| clr_full_i | input | NUM_BUF | Full-flag clear strobe per buffer |
| done_o | output | 1 | Decision pulse |
| done_res_o | output | 2 | Result: 0 store, 1 deferred, 2 FIFO, 3 drop |
| done_idx_o | output | IDX_W | Chosen buffer index |
| fifo_wr_o | output | 1 | FIFO write strobe |
| lost_o | output | 1 | Frame-lost error pulse |
| upd_o | output | NUM_BUF | Buffer update strobes |
| full_o | output | NUM_BUF | Buffer full flags |
| irq_o | output | 1 | Receive interrupt |

## Verification
The hardest state to reach from the ports is a buffer that is locked while two frames aimed at it arrive, followed by a release. This state exercises the shadow slots, the overwrite of the parked frame, the lost pulse and the single delivery. The bench first raises the lock request and confirms the acknowledge. It then sends two frames that the locked buffer's filter accepts, on different channels, with a frame for another buffer in between. Finally it drops the request and watches the strobe over two cycles. Before this, a sweep over identifiers, cycle values and channels is run against a fixed set of overlapping filters. The filters include a disabled catch-all and a buffer inside the FIFO region, so that first-hit order, the FIFO fallback and the drop path are all resolved against a model kept in the bench.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    RES_STORE = 2'd0,
    RES_DEFER = 2'd1,
    RES_FIFO  = 2'd2,
    RES_DROP  = 2'd3
  } res_e;
endpackage

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int ID_W  = 11,
  parameter int CYC_W = 6
) (
  input  logic [ID_W-1:0]  id_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             chan_i,
  input  logic [ID_W-1:0]  f_id_i,
  input  logic [ID_W-1:0]  f_id_msk_i,
  input  logic [CYC_W-1:0] f_cyc_i,
  input  logic [CYC_W-1:0] f_cyc_msk_i,
  input  logic             f_chan_i,
  input  logic             f_chan_msk_i,
  output logic             hit_o
);
  logic id_ok, cyc_ok, chan_ok;
  assign id_ok   = ((id_i ^ f_id_i) & f_id_msk_i) == '0;
  assign cyc_ok  = ((cyc_i ^ f_cyc_i) & f_cyc_msk_i) == '0;
  assign chan_ok = !f_chan_msk_i || (chan_i == f_chan_i);
  assign hit_o   = id_ok && cyc_ok && chan_ok;
endmodule

// File: rtl/rxf_scan.sv
module rxf_scan
  import rxf_pkg::*;
#(
  parameter int NUM_BUF   = 8,
  parameter int FIFO_BUFS = 2,
  parameter int ID_W      = 11,
  parameter int CYC_W     = 6,
  parameter int IDX_W     = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frm_valid_i,
  input  logic               frm_ok_i,
  input  logic [ID_W-1:0]    frm_id_i,
  input  logic [CYC_W-1:0]   frm_cyc_i,
  input  logic               frm_chan_i,
  input  logic [NUM_BUF-1:0] hit_i,
  input  logic               fifo_hit_i,
  input  logic [NUM_BUF-1:0] locked_i,
  output logic [ID_W-1:0]    cur_id_o,
  output logic [CYC_W-1:0]   cur_cyc_o,
  output logic               cur_chan_o,
  output logic               dec_o,
  output res_e               dec_res_o,
  output logic [IDX_W-1:0]   dec_idx_o,
  output logic               done_o,
  output res_e               done_res_o,
  output logic [IDX_W-1:0]   done_idx_o,
  output logic               fifo_wr_o
);
  localparam logic [IDX_W-1:0] FIRST = IDX_W'(FIFO_BUFS);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_BUF - 1);

  logic             busy_q;
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    dec_o     = 1'b0;
    dec_res_o = RES_DROP;
    dec_idx_o = ptr_q;
    if (busy_q) begin
      if (hit_i[ptr_q]) begin
        dec_o     = 1'b1;
        dec_res_o = locked_i[ptr_q] ? RES_DEFER : RES_STORE;
      end else if (ptr_q == LAST) begin
        dec_o     = 1'b1;
        dec_res_o = fifo_hit_i ? RES_FIFO : RES_DROP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ptr_q      <= FIRST;
      cur_id_o   <= '0;
      cur_cyc_o  <= '0;
      cur_chan_o <= 1'b0;
      done_o     <= 1'b0;
      done_res_o <= RES_DROP;
      done_idx_o <= '0;
      fifo_wr_o  <= 1'b0;
    end else begin
      if (!busy_q) begin
        if (frm_valid_i && frm_ok_i) begin
          busy_q     <= 1'b1;
          ptr_q      <= FIRST;
          cur_id_o   <= frm_id_i;
          cur_cyc_o  <= frm_cyc_i;
          cur_chan_o <= frm_chan_i;
        end
      end else if (dec_o) begin
        busy_q <= 1'b0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
      done_o     <= dec_o;
      done_res_o <= dec_res_o;
      done_idx_o <= dec_idx_o;
      fifo_wr_o  <= dec_o && (dec_res_o == RES_FIFO);
    end
  end

  // R1
  invalid_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && frm_valid_i && !frm_ok_i) |=> !busy_q);
  // R2
  scan_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (done_res_o == RES_STORE || done_res_o == RES_DEFER)) |-> (done_idx_o >= FIRST));
  // R10
  done_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/rxf_shadow.sv
module rxf_shadow #(
  parameter int NUM_BUF = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               defer_i,
  input  logic [IDX_W-1:0]   defer_idx_i,
  input  logic               defer_chan_i,
  input  logic [NUM_BUF-1:0] release_i,
  output logic [NUM_BUF-1:0] deliver_o,
  output logic               lost_o
);
  localparam int NSLOT = 4;  // two per channel; slot bit 1 selects channel

  logic [NSLOT-1:0] slot_v;
  logic [IDX_W-1:0] slot_t [NSLOT];
  logic [NSLOT-1:0] same, alloc;
  logic             any_same;

  always_comb begin
    deliver_o = '0;
    same      = '0;
    alloc     = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot_v[s] && release_i[slot_t[s]]) deliver_o[slot_t[s]] = 1'b1;
      same[s] = slot_v[s] && (slot_t[s] == defer_idx_i);
    end
    for (int s = 0; s < NSLOT; s++) begin
      if (!slot_v[s] && (((s / 2) != 0) == defer_chan_i) && (alloc == '0)) alloc[s] = 1'b1;
    end
    any_same = |same;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v <= '0;
      for (int s = 0; s < NSLOT; s++) slot_t[s] <= '0;
      lost_o <= 1'b0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (slot_v[s] && release_i[slot_t[s]]) slot_v[s] <= 1'b0;
        if (defer_i && !any_same && alloc[s]) begin
          slot_v[s] <= 1'b1;
          slot_t[s] <= defer_idx_i;
        end
      end
      lost_o <= defer_i && (any_same || (alloc == '0));
    end
  end

  for (genvar a = 0; a < NSLOT; a++) begin : g_pa
    for (genvar b = a + 1; b < NSLOT; b++) begin : g_pb
      // R9
      single_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(slot_v[a] && slot_v[b] && (slot_t[a] == slot_t[b])));
    end
  end
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int NUM_BUF = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BUF-1:0] lock_req_i,
  input  logic [NUM_BUF-1:0] clr_i,
  input  logic [NUM_BUF-1:0] wr_i,
  input  logic [NUM_BUF-1:0] deliver_i,
  input  logic [NUM_BUF-1:0] irq_en_i,
  output logic [NUM_BUF-1:0] ack_o,
  output logic [NUM_BUF-1:0] locked_o,
  output logic [NUM_BUF-1:0] release_o,
  output logic [NUM_BUF-1:0] upd_o,
  output logic [NUM_BUF-1:0] full_o,
  output logic               irq_o
);
  // a buffer being released this edge counts as unlocked
  assign locked_o  = ack_o & lock_req_i;
  assign release_o = ack_o & ~lock_req_i;
  assign irq_o     = |(full_o & irq_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o  <= '0;
      full_o <= '0;
      upd_o  <= '0;
    end else begin
      ack_o  <= lock_req_i;
      full_o <= (full_o & ~clr_i) | wr_i | deliver_i;
      upd_o  <= wr_i | deliver_i;
    end
  end

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_chk
    // R8
    locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_o[i] |-> !wr_i[i]);
    // R5
    full_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i[i] || deliver_i[i]) |=> full_o[i]);
  end
endmodule

// File: rtl/rx_filter_engine.sv
module rx_filter_engine
  import rxf_pkg::*;
#(
  parameter int NUM_BUF   = 8,
  parameter int FIFO_BUFS = 2,
  parameter int ID_W      = 11,
  parameter int CYC_W     = 6,
  localparam int IDX_W    = $clog2(NUM_BUF)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frm_valid_i,
  input  logic                     frm_ok_i,
  input  logic [ID_W-1:0]          frm_id_i,
  input  logic [CYC_W-1:0]         frm_cyc_i,
  input  logic                     frm_chan_i,
  input  logic [NUM_BUF-1:0]       buf_en_i,
  input  logic [NUM_BUF*ID_W-1:0]  buf_id_i,
  input  logic [NUM_BUF*ID_W-1:0]  buf_id_msk_i,
  input  logic [NUM_BUF*CYC_W-1:0] buf_cyc_i,
  input  logic [NUM_BUF*CYC_W-1:0] buf_cyc_msk_i,
  input  logic [NUM_BUF-1:0]       buf_chan_i,
  input  logic [NUM_BUF-1:0]       buf_chan_msk_i,
  input  logic [NUM_BUF-1:0]       irq_en_i,
  input  logic                     fifo_en_i,
  input  logic [ID_W-1:0]          fifo_id_i,
  input  logic [ID_W-1:0]          fifo_id_msk_i,
  input  logic [CYC_W-1:0]         fifo_cyc_i,
  input  logic [CYC_W-1:0]         fifo_cyc_msk_i,
  input  logic                     fifo_chan_i,
  input  logic                     fifo_chan_msk_i,
  input  logic [NUM_BUF-1:0]       lock_req_i,
  output logic [NUM_BUF-1:0]       lock_ack_o,
  input  logic [NUM_BUF-1:0]       clr_full_i,
  output logic                     done_o,
  output logic [1:0]               done_res_o,
  output logic [IDX_W-1:0]         done_idx_o,
  output logic                     fifo_wr_o,
  output logic                     lost_o,
  output logic [NUM_BUF-1:0]       upd_o,
  output logic [NUM_BUF-1:0]       full_o,
  output logic                     irq_o
);
  logic [ID_W-1:0]    cur_id;
  logic [CYC_W-1:0]   cur_cyc;
  logic               cur_chan;
  logic [NUM_BUF-1:0] raw_hit, hit, locked, release_v, deliver, wr_vec;
  logic               fifo_raw, dec;
  res_e               dec_res, dn_res;
  logic [IDX_W-1:0]   dec_idx;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_flt
    rxf_match #(.ID_W(ID_W), .CYC_W(CYC_W)) u_match (
      .id_i(cur_id), .cyc_i(cur_cyc), .chan_i(cur_chan),
      .f_id_i(buf_id_i[i*ID_W +: ID_W]), .f_id_msk_i(buf_id_msk_i[i*ID_W +: ID_W]),
      .f_cyc_i(buf_cyc_i[i*CYC_W +: CYC_W]), .f_cyc_msk_i(buf_cyc_msk_i[i*CYC_W +: CYC_W]),
      .f_chan_i(buf_chan_i[i]), .f_chan_msk_i(buf_chan_msk_i[i]),
      .hit_o(raw_hit[i])
    );
  end
  assign hit = raw_hit & buf_en_i;

  rxf_match #(.ID_W(ID_W), .CYC_W(CYC_W)) u_fifo_match (
    .id_i(cur_id), .cyc_i(cur_cyc), .chan_i(cur_chan),
    .f_id_i(fifo_id_i), .f_id_msk_i(fifo_id_msk_i),
    .f_cyc_i(fifo_cyc_i), .f_cyc_msk_i(fifo_cyc_msk_i),
    .f_chan_i(fifo_chan_i), .f_chan_msk_i(fifo_chan_msk_i),
    .hit_o(fifo_raw)
  );

  rxf_scan #(.NUM_BUF(NUM_BUF), .FIFO_BUFS(FIFO_BUFS), .ID_W(ID_W), .CYC_W(CYC_W),
             .IDX_W(IDX_W)) u_scan (
    .clk_i, .rst_ni, .frm_valid_i, .frm_ok_i, .frm_id_i, .frm_cyc_i, .frm_chan_i,
    .hit_i(hit), .fifo_hit_i(fifo_raw && fifo_en_i), .locked_i(locked),
    .cur_id_o(cur_id), .cur_cyc_o(cur_cyc), .cur_chan_o(cur_chan),
    .dec_o(dec), .dec_res_o(dec_res), .dec_idx_o(dec_idx),
    .done_o, .done_res_o(dn_res), .done_idx_o, .fifo_wr_o
  );
  assign done_res_o = dn_res;

  always_comb begin
    wr_vec = '0;
    if (dec && dec_res == RES_STORE) wr_vec[dec_idx] = 1'b1;
  end

  rxf_shadow #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_shadow (
    .clk_i, .rst_ni,
    .defer_i(dec && dec_res == RES_DEFER), .defer_idx_i(dec_idx), .defer_chan_i(cur_chan),
    .release_i(release_v), .deliver_o(deliver), .lost_o
  );

  rxf_flags #(.NUM_BUF(NUM_BUF)) u_flags (
    .clk_i, .rst_ni, .lock_req_i, .clr_i(clr_full_i), .wr_i(wr_vec), .deliver_i(deliver),
    .irq_en_i, .ack_o(lock_ack_o), .locked_o(locked), .release_o(release_v),
    .upd_o, .full_o, .irq_o
  );
endmodule

// File: tb/test_rx_filter_engine.sv
`timescale 1ns/1ps
module test_rx_filter_engine;
  localparam int NB = 8, FB = 2, IW = 11, CW = 6;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic          frm_valid = 0, frm_ok = 0, frm_chan = 0;
  logic [IW-1:0] frm_id = '0;
  logic [CW-1:0] frm_cyc = '0;
  logic [IW-1:0] m_id [NB], m_idm [NB];
  logic [CW-1:0] m_cyc [NB], m_cycm [NB];
  logic [NB-1:0] m_en, m_ch, m_chm, m_irq;
  logic [NB*IW-1:0] v_id, v_idm;
  logic [NB*CW-1:0] v_cyc, v_cycm;
  logic [NB-1:0] lock_req = '0, clr = '0;
  logic [NB-1:0] lock_ack, upd, full;
  logic done, fifo_wr, lost, irq;
  logic [1:0] res;
  logic [2:0] idx;
  localparam logic [IW-1:0] F_ID = 11'd8, F_IDM = 11'h7FC;
  localparam logic [CW-1:0] F_CYC = 6'd0, F_CYCM = 6'h3F;

  always_comb
    for (int i = 0; i < NB; i++) begin
      v_id[i*IW +: IW] = m_id[i];  v_idm[i*IW +: IW] = m_idm[i];
      v_cyc[i*CW +: CW] = m_cyc[i]; v_cycm[i*CW +: CW] = m_cycm[i];
    end

  rx_filter_engine i_rx_filter_engine (
    .clk_i(clk), .rst_ni(rst_n), .frm_valid_i(frm_valid), .frm_ok_i(frm_ok),
    .frm_id_i(frm_id), .frm_cyc_i(frm_cyc), .frm_chan_i(frm_chan),
    .buf_en_i(m_en), .buf_id_i(v_id), .buf_id_msk_i(v_idm), .buf_cyc_i(v_cyc),
    .buf_cyc_msk_i(v_cycm), .buf_chan_i(m_ch), .buf_chan_msk_i(m_chm), .irq_en_i(m_irq),
    .fifo_en_i(1'b1), .fifo_id_i(F_ID), .fifo_id_msk_i(F_IDM), .fifo_cyc_i(F_CYC),
    .fifo_cyc_msk_i(F_CYCM), .fifo_chan_i(1'b0), .fifo_chan_msk_i(1'b0),
    .lock_req_i(lock_req), .lock_ack_o(lock_ack), .clr_full_i(clr),
    .done_o(done), .done_res_o(res), .done_idx_o(idx), .fifo_wr_o(fifo_wr),
    .lost_o(lost), .upd_o(upd), .full_o(full), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [NB-1:0] full_m = '0, lock_m = '0, pend_m = '0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit mt(input logic [IW-1:0] id, input logic [CW-1:0] cy, input logic ch,
                            input logic [IW-1:0] fid, input logic [IW-1:0] fidm,
                            input logic [CW-1:0] fc, input logic [CW-1:0] fcm,
                            input logic fch, input logic fchm);
    return (((id ^ fid) & fidm) == '0) && (((cy ^ fc) & fcm) == '0) && (!fchm || ch == fch);
  endfunction

  task automatic send(input logic [IW-1:0] id, input logic [CW-1:0] cy, input logic ch,
                      input logic ok);
    @(negedge clk);
    frm_valid = 1; frm_ok = ok; frm_id = id; frm_cyc = cy; frm_chan = ch;
    @(negedge clk);
    frm_valid = 0;
  endtask

  // R2 R3 R4 R5 R6 R8 R9 R10 R11 checked per frame against the bench model
  task automatic run(input logic [IW-1:0] id, input logic [CW-1:0] cy, input logic ch);
    int hi = -1, off, e_res, cnt = 0;
    bit e_lost = 0;
    logic [NB-1:0] e_upd = '0;
    for (int i = FB; i < NB; i++)
      if (hi < 0 && m_en[i] && mt(id, cy, ch, m_id[i], m_idm[i], m_cyc[i], m_cycm[i], m_ch[i], m_chm[i]))
        hi = i;
    if (hi >= 0) begin
      off = hi - FB;
      if (lock_m[hi]) begin e_res = 1; e_lost = pend_m[hi]; pend_m[hi] = 1; end
      else begin e_res = 0; full_m[hi] = 1; e_upd[hi] = 1; end
    end else begin
      off = NB - 1 - FB;
      e_res = mt(id, cy, ch, F_ID, F_IDM, F_CYC, F_CYCM, 1'b0, 1'b0) ? 2 : 3;
    end
    send(id, cy, ch, 1'b1);
    while (!done && cnt < 20) begin @(negedge clk); cnt++; end
    chk("R10 latency", cnt, off + 1);
    chk("R2/R3/R11 result", int'(res), e_res);
    if (hi >= 0) chk("R2/R4 index", int'(idx), hi);
    chk("R3 fifo strobe", int'(fifo_wr), int'(e_res == 2));
    chk("R9 lost", int'(lost), int'(e_lost));
    chk("R5/R8 update", int'(upd), int'(e_upd));
    chk("R5 full", int'(full), int'(full_m));
    chk("R6 irq", int'(irq), int'(|(full_m & m_irq)));
  endtask

  task automatic clear_all();
    @(negedge clk); clr = '1;
    @(negedge clk); clr = '0;
    full_m = '0;
    chk("R6 clear full", int'(full), 0);
    chk("R6 clear irq", int'(irq), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      m_id[i] = '0; m_idm[i] = '0; m_cyc[i] = '0; m_cycm[i] = '0;
    end
    m_en = '0; m_ch = '0; m_chm = '0; m_irq = '0;
    // index 1 lies in the FIFO region and would catch everything
    m_en[1] = 1;
    m_en[2] = 1; m_id[2] = 5;  m_idm[2] = 11'h7FF;
    m_en[3] = 1; m_id[3] = 4;  m_idm[3] = 11'h7FC; m_chm[3] = 1; m_ch[3] = 0;
    m_en[4] = 0;
    m_en[5] = 1; m_id[5] = 0;  m_idm[5] = 11'h7F8; m_cyc[5] = 5; m_cycm[5] = 6'h3F;
    m_en[6] = 1; m_id[6] = 8;  m_idm[6] = 11'h7F8; m_chm[6] = 1; m_ch[6] = 1;
    m_en[7] = 1; m_id[7] = 12; m_idm[7] = 11'h7FF;
    m_irq = 8'b1010_1100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset done", int'(done), 0);
    chk("reset full", int'(full), 0);
    chk("reset irq", int'(irq), 0);
    chk("R7 reset ack", int'(lock_ack), 0);

    // R1: malformed frames touch nothing
    for (int k = 0; k < 3; k++) begin
      bit seen = 0;
      send(11'(5 + k * 3), 6'd0, 1'b0, 1'b0);
      repeat (10) begin @(negedge clk); seen |= done | (|upd); end
      chk("R1 invalid ignored", int'(seen), 0);
      chk("R1 full unchanged", int'(full), 0);
    end

    for (int id = 0; id < 16; id++)
      for (int c = 0; c < 2; c++)
        for (int ch = 0; ch < 2; ch++) begin
          run(11'(id), c ? 6'd5 : 6'd0, ch[0]);
          if ((id % 4) == 3 && c == 1 && ch == 1) clear_all();
        end
    clear_all();

    // R7 R8 R9: lock, two deferred frames, release
    @(negedge clk); lock_req[2] = 1;
    @(negedge clk);
    chk("R7 lock ack", int'(lock_ack[2]), 1);
    lock_m[2] = 1;
    run(11'd5, 6'd0, 1'b0);
    run(11'd12, 6'd0, 1'b0);
    run(11'd5, 6'd1, 1'b1);
    chk("R8 locked not full", int'(full[2]), 0);
    lock_req[2] = 0;
    @(negedge clk);
    chk("R7 unlock ack", int'(lock_ack[2]), 0);
    chk("R8 deliver strobe", int'(upd), 4);
    chk("R8 deliver full", int'(full[2]), 1);
    chk("R6 irq after deliver", int'(irq), 1);
    @(negedge clk);
    chk("R9 single delivery", int'(upd), 0);
    lock_m[2] = 0; pend_m[2] = 0; full_m[2] = 1;
    run(11'd5, 6'd2, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule